// File: doc/BRIEF.md
# Paletted Framebuffer Pixel Fetcher

This block is the pixel-formatting stage of a display controller. An external timing source presents a pixel-position strobe with X and Y coordinates. For each strobe the block decides whether the position falls inside a programmable framebuffer window. For positions inside the window it computes the byte address in memory, issues a read on a simple read port and turns the returned data into one 24-bit RGB pixel. Positions outside the window, and all positions while the display is switched off, come out black.

Four pixel layouts are supported: two direct 16-bit colour layouts (5-5-5 and 5-6-5) and two indexed layouts (one byte per pixel, or one nibble per pixel). The indexed layouts look colours up in an internal 256-entry palette. Software loads the palette by setting a write position and then streaming entries into a data register; each stored entry moves the position on by one. All settings come in through a single-cycle configuration write port.

Top module: `fb_pixel_fetcher`

## Requirements
- R1: After reset the window is X offset 96, width 854, Y offset 8, height 480, with base address 0, stride 0, format 0 and the display off; a position is inside the window when xoff <= x < xoff+width and yoff <= y < yoff+height.
- R2: The display is on only while bits 1 and 4 of the control register are both 1, other bits having no effect; while it is off every pixel is black and no memory read is issued.
- R3: A strobe at a position outside the window issues no memory read and yields a black pixel (0x000000).
- R4: For an inside position with col = x-xoff and row = y-yoff, `mem_req` is high in the strobe cycle and `mem_addr` = base + row*stride + off, where off is col for format 0, col/2 (rounded down) for format 1 and 2*col for formats 2 and 3; with no strobe there is no read.
- R5: Format 0: the palette index is `mem_rdata[7:0]`, the byte stored at `mem_addr`; the memory returns `mem_rdata` = {byte at addr+1, byte at addr} in the cycle after the request.
- R6: Format 1: each byte holds two pixels; an even col uses bits 3:0 of the byte as the index and an odd col uses bits 7:4.
- R7: Format 2: the 16-bit word gives red in bits 14:10, green in 9:5 and blue in 4:0, bit 15 ignored; each 5-bit field widens to 8 bits as {f, f[4:2]}.
- R8: Format 3: red in bits 15:11, green in 10:5, blue in 4:0; 5-bit fields widen as {f, f[4:2]} and the 6-bit field as {f, f[5:4]}.
- R9: A palette entry is 32 bits with red in 7:0, green in 15:8, blue in 23:16 and alpha in 31:24; alpha is ignored and `out_rgb` is {red, green, blue} with red in bits 23:16.
- R10: A write to the palette position register sets the position from `cfg_wdata[7:0]`; each palette data write stores the entry at the current position and advances it by one, wrapping from 255 to 0.
- R11: `out_vld` rises exactly two clock edges after the strobe edge, carrying that strobe's pixel, and `out_rgb` is 0 whenever `out_vld` is low.
- R12: Configuration addresses on `cfg_addr`: 0 control, 1 format (bits 1:0), 2 X offset, 3 width, 4 Y offset, 5 height, 6 stride in bytes, 7 base address, 8 palette position, 9 palette data; a write takes effect at the edge on which `cfg_we` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| pix_vld | input | 1 | Pixel-position strobe from the timing source |
| pix_x | input | 12 | Horizontal position of the strobe |
| pix_y | input | 12 | Vertical position of the strobe |
| mem_req | output | 1 | Memory read request, same cycle as the strobe |
| mem_addr | output | 32 | Byte address of the read |
| mem_rdata | input | 16 | Read data, one cycle after the request, low byte at `mem_addr` |
| out_vld | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output pixel, red in 23:16, green 15:8, blue 7:0 |

## Verification
The assertions watch, on every cycle, the two-stage progress of each strobe to the output, that an idle output is black, that a strobe outside the window or with the display off ends black, that no read happens without a strobe, and that every palette data write moves the position on by exactly one. The colour arithmetic of the four layouts, the nibble order, the address arithmetic with stride and offsets, the reset window and the placement of entries across the palette wrap can only be shown by the directed scenarios, which compare the port values against a memory image and palette image kept in the bench.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  typedef enum logic [1:0] {
    FMT_PAL8   = 2'd0,
    FMT_PAL4   = 2'd1,
    FMT_RGB555 = 2'd2,
    FMT_RGB565 = 2'd3
  } pix_fmt_e;

  typedef enum logic [3:0] {
    REG_CTRL   = 4'd0,
    REG_FMT    = 4'd1,
    REG_XOFF   = 4'd2,
    REG_WIDTH  = 4'd3,
    REG_YOFF   = 4'd4,
    REG_HEIGHT = 4'd5,
    REG_STRIDE = 4'd6,
    REG_BASE   = 4'd7,
    REG_PALPOS = 4'd8,
    REG_PALDAT = 4'd9
  } cfg_reg_e;

  typedef logic [23:0] rgb_t;

  // 5-bit channel to 8 bits by repeating its top bits
  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  // 6-bit channel to 8 bits by repeating its top bits
  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic rgb_t from_555(input logic [15:0] w);
    return {widen5(w[14:10]), widen5(w[9:5]), widen5(w[4:0])};
  endfunction

  function automatic rgb_t from_565(input logic [15:0] w);
    return {widen5(w[15:11]), widen6(w[10:5]), widen5(w[4:0])};
  endfunction

  // Palette word: alpha 31:24, blue 23:16, green 15:8, red 7:0
  function automatic rgb_t from_pal(input logic [31:0] e);
    return {e[7:0], e[15:8], e[23:16]};
  endfunction

  // Byte offset of a column inside one line
  function automatic logic [31:0] byte_off(input pix_fmt_e f, input logic [31:0] col);
    case (f)
      FMT_PAL8: return col;
      FMT_PAL4: return col >> 1;
      default:  return col << 1;
    endcase
  endfunction

endpackage

// File: rtl/fbf_regs.sv
module fbf_regs
  import fbf_pkg::*;
#(
  parameter int CW        = 12,
  parameter int AW        = 32,
  parameter int PAL_IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [3:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic                 disp_en,
  output pix_fmt_e             fmt,
  output logic [CW-1:0]        xoff,
  output logic [CW-1:0]        width,
  output logic [CW-1:0]        yoff,
  output logic [CW-1:0]        height,
  output logic [AW-1:0]        stride,
  output logic [AW-1:0]        base,
  output logic                 pal_we,
  output logic [PAL_IDX_W-1:0] pal_idx,
  output logic [31:0]          pal_wdata
);

  localparam logic [CW-1:0] XOFF_RST   = CW'(96);
  localparam logic [CW-1:0] WIDTH_RST  = CW'(854);
  localparam logic [CW-1:0] YOFF_RST   = CW'(8);
  localparam logic [CW-1:0] HEIGHT_RST = CW'(480);

  logic ctl_b1, ctl_b4;

  assign disp_en   = ctl_b1 & ctl_b4;
  assign pal_we    = cfg_we && (cfg_addr == REG_PALDAT);
  assign pal_wdata = cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_b1  <= 1'b0;
      ctl_b4  <= 1'b0;
      fmt     <= FMT_PAL8;
      xoff    <= XOFF_RST;
      width   <= WIDTH_RST;
      yoff    <= YOFF_RST;
      height  <= HEIGHT_RST;
      stride  <= '0;
      base    <= '0;
      pal_idx <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_CTRL: begin
          ctl_b1 <= cfg_wdata[1];
          ctl_b4 <= cfg_wdata[4];
        end
        REG_FMT:    fmt     <= pix_fmt_e'(cfg_wdata[1:0]);
        REG_XOFF:   xoff    <= cfg_wdata[CW-1:0];
        REG_WIDTH:  width   <= cfg_wdata[CW-1:0];
        REG_YOFF:   yoff    <= cfg_wdata[CW-1:0];
        REG_HEIGHT: height  <= cfg_wdata[CW-1:0];
        REG_STRIDE: stride  <= cfg_wdata[AW-1:0];
        REG_BASE:   base    <= cfg_wdata[AW-1:0];
        REG_PALPOS: pal_idx <= cfg_wdata[PAL_IDX_W-1:0];
        REG_PALDAT: pal_idx <= pal_idx + 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fbf_palette.sv
module fbf_palette #(
  parameter int PAL_IDX_W = 8,
  parameter int EW        = 32
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [PAL_IDX_W-1:0] widx,
  input  logic [EW-1:0]        wdata,
  input  logic [PAL_IDX_W-1:0] ridx,
  output logic [EW-1:0]        rdata
);

  localparam int DEPTH = 1 << PAL_IDX_W;

  logic [EW-1:0] ent [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ent[widx] <= wdata;
  end

  assign rdata = ent[ridx];

endmodule

// File: rtl/fbf_addr.sv
module fbf_addr
  import fbf_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 32
) (
  input  logic          pix_vld,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic [CW-1:0] xoff,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] yoff,
  input  logic [CW-1:0] height,
  input  logic [AW-1:0] stride,
  input  logic [AW-1:0] base,
  input  pix_fmt_e      fmt,
  input  logic          disp_en,
  output logic          win_hit,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          col_odd
);

  localparam int EXW = CW + 1;

  logic [EXW-1:0] x_end, y_end;
  logic [CW-1:0]  col, row;
  logic           x_in, y_in;
  logic [AW-1:0]  line_start;

  assign x_end = {1'b0, xoff} + {1'b0, width};
  assign y_end = {1'b0, yoff} + {1'b0, height};
  assign x_in  = (pix_x >= xoff) && ({1'b0, pix_x} < x_end);
  assign y_in  = (pix_y >= yoff) && ({1'b0, pix_y} < y_end);

  assign win_hit = x_in && y_in;
  assign col     = pix_x - xoff;
  assign row     = pix_y - yoff;
  assign col_odd = col[0];

  assign line_start = base + AW'(AW'(row) * stride);
  assign mem_addr   = line_start + AW'(byte_off(fmt, 32'(col)));
  assign mem_req    = pix_vld && win_hit && disp_en;

endmodule

// File: rtl/fb_pixel_fetcher.sv
module fb_pixel_fetcher
  import fbf_pkg::*;
#(
  parameter int CW        = 12,
  parameter int AW        = 32,
  parameter int PAL_IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          pix_vld,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          out_vld,
  output logic [23:0]   out_rgb
);

  localparam int PEW = 32;

  // configuration
  logic                 disp_en;
  pix_fmt_e             fmt;
  logic [CW-1:0]        xoff, width, yoff, height;
  logic [AW-1:0]        stride, base;
  logic                 pal_we;
  logic [PAL_IDX_W-1:0] pal_idx;
  logic [31:0]          pal_wdata;

  // stage 0 events
  logic win_hit, col_odd;

  // stage 1 state
  logic     s1_vld, s1_show, s1_odd;
  pix_fmt_e s1_fmt;

  logic [PAL_IDX_W-1:0] pal_ridx;
  logic [PEW-1:0]       pal_rdata;
  rgb_t                 pix_color;

  fbf_regs #(.CW(CW), .AW(AW), .PAL_IDX_W(PAL_IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .disp_en   (disp_en),
    .fmt       (fmt),
    .xoff      (xoff),
    .width     (width),
    .yoff      (yoff),
    .height    (height),
    .stride    (stride),
    .base      (base),
    .pal_we    (pal_we),
    .pal_idx   (pal_idx),
    .pal_wdata (pal_wdata)
  );

  fbf_addr #(.CW(CW), .AW(AW)) u_addr (
    .pix_vld  (pix_vld),
    .pix_x    (pix_x),
    .pix_y    (pix_y),
    .xoff     (xoff),
    .width    (width),
    .yoff     (yoff),
    .height   (height),
    .stride   (stride),
    .base     (base),
    .fmt      (fmt),
    .disp_en  (disp_en),
    .win_hit  (win_hit),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .col_odd  (col_odd)
  );

  fbf_palette #(.PAL_IDX_W(PAL_IDX_W), .EW(PEW)) u_pal (
    .clk   (clk),
    .we    (pal_we),
    .widx  (pal_idx),
    .wdata (pal_wdata),
    .ridx  (pal_ridx),
    .rdata (pal_rdata)
  );

  // stage 1: memory data returns during this stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_show <= 1'b0;
      s1_odd  <= 1'b0;
      s1_fmt  <= FMT_PAL8;
    end else begin
      s1_vld  <= pix_vld;
      s1_show <= pix_vld && win_hit && disp_en;
      s1_odd  <= col_odd;
      s1_fmt  <= fmt;
    end
  end

  always_comb begin
    pal_ridx = '0;
    case (s1_fmt)
      FMT_PAL8: pal_ridx = PAL_IDX_W'(mem_rdata[7:0]);
      FMT_PAL4: pal_ridx = PAL_IDX_W'(s1_odd ? mem_rdata[7:4] : mem_rdata[3:0]);
      default:  pal_ridx = '0;
    endcase
  end

  always_comb begin
    case (s1_fmt)
      FMT_RGB555: pix_color = from_555(mem_rdata);
      FMT_RGB565: pix_color = from_565(mem_rdata);
      default:    pix_color = from_pal(pal_rdata);
    endcase
  end

  // stage 2: registered output
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_rgb <= '0;
    end else begin
      out_vld <= s1_vld;
      out_rgb <= (s1_vld && s1_show) ? pix_color : '0;
    end
  end

endmodule

// File: rtl/fbf_checks.sv
module fbf_checks #(
  parameter int PAL_IDX_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pix_vld,
  input logic                 mem_req,
  input logic                 win_hit,
  input logic                 disp_en,
  input logic                 s1_vld,
  input logic                 out_vld,
  input logic [23:0]          out_rgb,
  input logic                 pal_we,
  input logic [PAL_IDX_W-1:0] pal_idx
);

  AST_STAGE1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> s1_vld); // R11

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> out_vld); // R11

  AST_IDLE_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_rgb == 24'd0)); // R11

  AST_OUTSIDE_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !win_hit) |=> ##1 (out_rgb == 24'd0)); // R3

  AST_DISABLED_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !disp_en) |=> ##1 (out_rgb == 24'd0)); // R2

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |-> !mem_req); // R4

  AST_PAL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |=> (pal_idx == $past(pal_idx) + 1'b1)); // R10

endmodule

bind fb_pixel_fetcher fbf_checks #(.PAL_IDX_W(PAL_IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pix_vld (pix_vld),
  .mem_req (mem_req),
  .win_hit (win_hit),
  .disp_en (disp_en),
  .s1_vld  (s1_vld),
  .out_vld (out_vld),
  .out_rgb (out_rgb),
  .pal_we  (pal_we),
  .pal_idx (pal_idx)
);

// File: tb/fb_pixel_fetcher_test.sv
module fb_pixel_fetcher_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pix_vld = 1'b0;
  logic [11:0] pix_x = '0;
  logic [11:0] pix_y = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        out_vld;
  logic [23:0] out_rgb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench images of memory and palette
  logic [7:0]  bmem [4096];
  logic [31:0] pal_img [256];

  // bench copy of configuration
  int g_xo = 96, g_w = 854, g_yo = 8, g_h = 480, g_stride = 0, g_base = 0, g_fmt = 0;

  always #10 clk = ~clk;

  fb_pixel_fetcher uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_vld(pix_vld), .pix_x(pix_x), .pix_y(pix_y), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .out_vld(out_vld), .out_rgb(out_rgb)
  );

  always @(posedge clk)
    if (mem_req) mem_rdata <= {bmem[mem_addr[11:0] + 12'd1], bmem[mem_addr[11:0]]};

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] pal_word(input int i);
    logic [7:0] v = 8'(i);
    return {v ^ 8'hC3, ~v, v ^ 8'h5A, v + 8'h11};
  endfunction

  function automatic logic [23:0] pal_rgb(input logic [31:0] e);
    return {e[7:0], e[15:8], e[23:16]};
  endfunction

  function automatic logic [7:0] grow(input int v, input int bits);
    return 8'((v << (8 - bits)) | (v >> (2 * bits - 8)));
  endfunction

  function automatic int exp_addr(input int x, input int y);
    int col = x - g_xo;
    int row = y - g_yo;
    int off = (g_fmt == 0) ? col : (g_fmt == 1) ? col / 2 : col * 2;
    return g_base + row * g_stride + off;
  endfunction

  function automatic logic [23:0] exp_rgb(input int x, input int y);
    int a = exp_addr(x, y) & 4095;
    int b0 = bmem[a];
    int w = b0 + 256 * bmem[(a + 1) & 4095];
    int col = x - g_xo;
    case (g_fmt)
      0: return pal_rgb(pal_img[b0]);
      1: return pal_rgb(pal_img[(col % 2 == 1) ? (b0 / 16) : (b0 % 16)]);
      2: return {grow((w / 1024) % 32, 5), grow((w / 32) % 32, 5), grow(w % 32, 5)};
      default: return {grow(w / 2048, 5), grow((w / 32) % 64, 6), grow(w % 32, 5)};
    endcase
  endfunction

  // present one strobe, check the read port, then the output two edges later
  task automatic probe(input string req, input int x, input int y, input bit shown);
    logic [23:0] er;
    er = shown ? exp_rgb(x, y) : 24'd0;
    @(negedge clk);
    pix_vld = 1'b1; pix_x = 12'(x); pix_y = 12'(y);
    #1;
    check(req, "mem_req", 32'(mem_req), 32'(shown));
    if (shown) check(req, "mem_addr", mem_addr, 32'(exp_addr(x, y)));
    @(negedge clk);
    pix_vld = 1'b0;
    check(req, "out_vld early", 32'(out_vld), 32'd0);
    @(negedge clk);
    check(req, "out_vld", 32'(out_vld), 32'd1);
    check(req, "out_rgb", 32'(out_rgb), 32'(er));
  endtask

  task automatic t_reset();
    check("R11", "reset out_vld", 32'(out_vld), 32'd0);
    check("R11", "reset out_rgb", 32'(out_rgb), 32'd0);
    check("R2", "reset mem_req", 32'(mem_req), 32'd0);
  endtask

  task automatic t_pal_load();  // R10, R12 loading through the position and data registers
    cfg(8, 0);
    for (int i = 0; i < 256; i++) begin
      pal_img[i] = pal_word(i);
      cfg(9, pal_img[i]);
    end
  endtask

  task automatic t_defaults();  // R1 reset window, with display enabled
    cfg(0, 32'h12);
    probe("R1", 95, 8, 0);
    probe("R1", 96, 8, 1);
    probe("R1", 949, 487, 1);
    probe("R1", 950, 8, 0);
    probe("R1", 96, 7, 0);
    probe("R1", 96, 488, 0);
  endtask

  task automatic t_enable();  // R2
    g_xo = 10; g_w = 20; g_yo = 5; g_h = 4; g_base = 'h100; g_stride = 64;
    cfg(2, g_xo); cfg(3, g_w); cfg(4, g_yo); cfg(5, g_h); cfg(7, g_base); cfg(6, g_stride);
    cfg(0, 32'h02);
    probe("R2", 12, 6, 0);
    cfg(0, 32'h10);
    probe("R2", 12, 6, 0);
    cfg(0, 32'hED);
    probe("R2", 12, 6, 0);
    cfg(0, 32'h13);
    probe("R2", 12, 6, 1);
  endtask

  task automatic t_window();  // R3
    probe("R3", 9, 5, 0);
    probe("R3", 30, 5, 0);
    probe("R3", 10, 9, 0);
    probe("R3", 10, 4, 0);
    probe("R3", 29, 8, 1);
  endtask

  task automatic t_pal8();  // R4 R5 R9
    g_fmt = 0; cfg(1, 0);
    probe("R5", 10, 5, 1);
    probe("R5", 17, 7, 1);
    probe("R9", 29, 8, 1);
  endtask

  task automatic t_pal4();  // R4 R6
    g_fmt = 1; cfg(1, 1);
    bmem['h100] = 8'hA3;
    probe("R6", 10, 5, 1);
    probe("R6", 11, 5, 1);
    probe("R6", 28, 8, 1);
    probe("R6", 29, 8, 1);
  endtask

  task automatic t_rgb555();  // R4 R7
    g_fmt = 2; cfg(1, 2);
    bmem['h100] = 8'hFF; bmem['h101] = 8'h7F;
    probe("R7", 10, 5, 1);
    bmem['h100] = 8'h21; bmem['h101] = 8'hC6;
    probe("R7", 10, 5, 1);
    probe("R7", 13, 7, 1);
  endtask

  task automatic t_rgb565();  // R4 R8
    g_fmt = 3; cfg(1, 3);
    bmem['h100] = 8'hE0; bmem['h101] = 8'h07;
    probe("R8", 10, 5, 1);
    bmem['h100] = 8'h1F; bmem['h101] = 8'hF8;
    probe("R8", 10, 5, 1);
    probe("R8", 22, 6, 1);
  endtask

  task automatic t_pal_wrap();  // R10
    g_fmt = 0; cfg(1, 0);
    cfg(8, 255);
    pal_img[255] = 32'h00ABCDEF;
    cfg(9, pal_img[255]);
    pal_img[0] = 32'hFF123456;
    cfg(9, pal_img[0]);
    bmem['h100] = 8'd255;
    bmem['h101] = 8'd0;
    probe("R10", 10, 5, 1);
    probe("R10", 11, 5, 1);
    check("R10", "entry255 rgb", 32'(pal_rgb(pal_img[255])), 32'h00EFCDAB);
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) bmem[k] = 8'(k * 7 + 3);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pal_load();
    t_defaults();
    t_enable();
    t_window();
    t_pal8();
    t_pal4();
    t_rgb555();
    t_rgb565();
    t_pal_wrap();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule